// File: doc/BRIEF.md
# Host-Driven Address Gate Sequence Decoder

This block sits beside the host-facing input buffer of a keyboard-style slave controller. It watches every host write, and once it has been armed it handles the "write output port" command sequence in hardware. The sequence is a command byte D1h, then a data byte, then an optional closing command byte FFh. Bit 1 of the data byte goes straight to a dedicated gate output. The local processor takes no part in this.

For each write that belongs to a valid sequence, the block raises a same-cycle suppress indication. The input buffer uses it to skip setting its full flag. Any other write, or any write made while the block is not armed, is left to the buffer's normal flag handling. A command other than D1h or FFh breaks a sequence in progress. The block can be armed by a one-cycle strobe at any time. It stays armed until reset.

Top module: `a20_gate_snoop`

## Requirements
- R1: Reset (rst_n low, asynchronous) drives gate_out to 0, disarms the block and returns the decoder to idle.
- R2: While not armed, ibf_suppress stays 0 for every write and gate_out holds its level.
- R3: A single-cycle arm_pulse arms the block, and it stays armed for any number of idle cycles until the next reset.
- R4: An armed command write (wr_cmd=1) of D1h raises ibf_suppress in its own cycle and leaves gate_out unchanged.
- R5: An armed data write (wr_cmd=0) that directly follows a D1h command raises ibf_suppress. From the next clock edge, gate_out equals data bit 1, and bits 7:2 and bit 0 have no effect.
- R6: A command write of FFh directly after a sequence's data byte raises ibf_suppress and leaves gate_out unchanged. An FFh command at any other time does not raise ibf_suppress.
- R7: Two D1h commands back to back, followed by a data write, form a valid sequence. All three writes are suppressed and the gate takes data bit 1.
- R8: If D1h is followed by any command other than D1h, that command is not suppressed. A data write after it is not suppressed either, and gate_out is unchanged.
- R9: A data write with no D1h pending is not suppressed and does not change gate_out.
- R10: A write in the same cycle as arm_pulse is handled as unarmed: it is not suppressed and starts no sequence.
- R11: gate_out changes only on the clock edge that ends a suppressed data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_pulse | input | 1 | One-cycle strobe that arms the decoder |
| wr_stb | input | 1 | One-cycle host write event |
| wr_cmd | input | 1 | Address select of the write: 1 command, 0 data |
| wr_data | input | 8 | Host write byte |
| gate_out | output | 1 | Dedicated gate level |
| ibf_suppress | output | 1 | Same-cycle request to the buffer not to set its full flag |

## Verification
The arm strobe and a host write can arrive in the same cycle. The bench provokes this by driving arm_pulse together with a D1h command. It then judges that the command was not suppressed, and that the data byte after it is treated as ordinary data: it is not suppressed and the gate stays put. Later sequences are then expected to work, which shows that the strobe still armed the block. Suppression is sampled just before the clock edge that takes the write, and the gate level is sampled both before and after that edge.

// File: rtl/a20_gate_snoop.sv
module a20_gate_snoop #(
  parameter int                DATA_W   = 8,
  parameter int                GATE_BIT = 1,
  parameter logic [DATA_W-1:0] SEQ_CMD  = 8'hD1,
  parameter logic [DATA_W-1:0] END_CMD  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_pulse,
  input  logic              wr_stb,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] wr_data,
  output logic              gate_out,
  output logic              ibf_suppress
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT_DATA, S_WAIT_END} seq_t;

  seq_t st, st_nx;
  logic armed;

  wire is_seq   = wr_cmd && (wr_data == SEQ_CMD);
  wire is_end   = wr_cmd && (wr_data == END_CMD);
  wire take_dat = !wr_cmd && (st == S_WAIT_DATA);
  wire snoop    = wr_stb && armed;

  assign ibf_suppress = snoop && (is_seq || take_dat || (is_end && st == S_WAIT_END));

  always_comb begin
    st_nx = st;
    if (snoop) begin
      if (is_seq)        st_nx = S_WAIT_DATA;
      else if (take_dat) st_nx = S_WAIT_END;
      else               st_nx = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      st       <= S_IDLE;
      gate_out <= 1'b0;
    end else begin
      if (arm_pulse) armed <= 1'b1;
      st <= st_nx;
      if (snoop && take_dat) gate_out <= wr_data[GATE_BIT];
    end
  end

endmodule

// File: rtl/a20_gate_snoop_chk.sv
module a20_gate_snoop_chk #(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] SEQ_CMD = 8'hD1,
  parameter logic [DATA_W-1:0] END_CMD = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_pulse,
  input logic              wr_stb,
  input logic              wr_cmd,
  input logic [DATA_W-1:0] wr_data,
  input logic              gate_out,
  input logic              ibf_suppress
);

  logic seen_arm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_arm <= 1'b0;
    else if (arm_pulse) seen_arm <= 1'b1;

  AST_RESET_GATE_LOW: assert property (@(posedge clk) !rst_n |=> !gate_out); // R1
  AST_NO_SUPPRESS_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_arm |-> !ibf_suppress); // R2
  AST_SUPPRESS_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_suppress |-> wr_stb); // R4
  AST_DATA_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_stb && wr_cmd && wr_data == SEQ_CMD && ibf_suppress) && wr_stb && !wr_cmd)
      |-> ibf_suppress); // R5
  AST_FOREIGN_CMD_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_cmd && wr_data != SEQ_CMD && wr_data != END_CMD) |-> !ibf_suppress); // R8
  AST_GATE_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out != $past(gate_out)) |-> $past(wr_stb && !wr_cmd && ibf_suppress)); // R11

endmodule

bind a20_gate_snoop a20_gate_snoop_chk #(
  .DATA_W(DATA_W), .SEQ_CMD(SEQ_CMD), .END_CMD(END_CMD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_pulse(arm_pulse), .wr_stb(wr_stb),
  .wr_cmd(wr_cmd), .wr_data(wr_data), .gate_out(gate_out),
  .ibf_suppress(ibf_suppress)
);

// File: tb/a20_gate_snoop_tb.sv
module a20_gate_snoop_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_pulse = 1'b0;
  logic       wr_stb = 1'b0;
  logic       wr_cmd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       gate_out;
  logic       ibf_suppress;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  a20_gate_snoop u_dut (
    .clk(clk), .rst_n(rst_n), .arm_pulse(arm_pulse), .wr_stb(wr_stb),
    .wr_cmd(wr_cmd), .wr_data(wr_data), .gate_out(gate_out),
    .ibf_suppress(ibf_suppress)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // One write; checks suppress and gate before the edge, gate after it.
  task automatic host_wr(input string tag, input logic cmd, input logic [7:0] d,
                         input logic exp_sup, input logic exp_gate_after,
                         input logic with_arm = 1'b0);
    logic g_before;
    @(negedge clk);
    wr_stb = 1'b1; wr_cmd = cmd; wr_data = d; arm_pulse = with_arm;
    #4;
    g_before = gate_out;
    check({tag, " suppress"}, ibf_suppress, exp_sup);
    @(negedge clk);
    wr_stb = 1'b0; arm_pulse = 1'b0;
    check({tag, " gate"}, gate_out, exp_gate_after);
    if (gate_out !== g_before)
      check({tag, " R11 gate moved on suppressed data only"}, exp_sup && !cmd, 1'b1);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 gate after reset", gate_out, 1'b0);
    check("R1 suppress idle", ibf_suppress, 1'b0);
  endtask

  task automatic t_unarmed;
    host_wr("R2 unarmed D1", 1'b1, 8'hD1, 1'b0, 1'b0);
    host_wr("R2 unarmed data", 1'b0, 8'h02, 1'b0, 1'b0);
  endtask

  task automatic t_arm_same_cycle;
    host_wr("R10 D1 with arm", 1'b1, 8'hD1, 1'b0, 1'b0, 1'b1);
    host_wr("R10 data after", 1'b0, 8'h02, 1'b0, 1'b0);
  endtask

  task automatic t_set;
    host_wr("R4 D1 armed", 1'b1, 8'hD1, 1'b1, 1'b0);
    host_wr("R5 set data", 1'b0, 8'h02, 1'b1, 1'b1);
    host_wr("R6 closing FF", 1'b1, 8'hFF, 1'b1, 1'b1);
  endtask

  task automatic t_clear;
    host_wr("R4 D1 clear", 1'b1, 8'hD1, 1'b1, 1'b1);
    host_wr("R5 clear data FD", 1'b0, 8'hFD, 1'b1, 1'b0);
    host_wr("R6 closing FF clr", 1'b1, 8'hFF, 1'b1, 1'b0);
  endtask

  task automatic t_double;
    host_wr("R7 first D1", 1'b1, 8'hD1, 1'b1, 1'b0);
    host_wr("R7 second D1", 1'b1, 8'hD1, 1'b1, 1'b0);
    host_wr("R7 data DF", 1'b0, 8'hDF, 1'b1, 1'b1);
    host_wr("R7 closing FF", 1'b1, 8'hFF, 1'b1, 1'b1);
  endtask

  task automatic t_stray_ff;
    host_wr("R6 stray FF", 1'b1, 8'hFF, 1'b0, 1'b1);
    host_wr("R6 FF right after D1", 1'b1, 8'hD1, 1'b1, 1'b1);
    host_wr("R6 FF breaks", 1'b1, 8'hFF, 1'b0, 1'b1);
  endtask

  task automatic t_invalid;
    host_wr("R8 D1", 1'b1, 8'hD1, 1'b1, 1'b1);
    host_wr("R8 foreign cmd", 1'b1, 8'hAB, 1'b0, 1'b1);
    host_wr("R8 data after break", 1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_idle_data;
    host_wr("R9 idle data", 1'b0, 8'h00, 1'b0, 1'b1);
    host_wr("R9 idle data 2", 1'b0, 8'hFD, 1'b0, 1'b1);
  endtask

  task automatic t_stays_armed;
    repeat (50) @(negedge clk);
    host_wr("R3 D1 after idle", 1'b1, 8'hD1, 1'b1, 1'b1);
    host_wr("R3 clear after idle", 1'b0, 8'h00, 1'b1, 1'b0);
    host_wr("R3 set after idle", 1'b1, 8'hD1, 1'b1, 1'b0);
    host_wr("R3 set data", 1'b0, 8'h02, 1'b1, 1'b1);
  endtask

  task automatic t_reset_disarms;
    do_reset();
    check("R1 gate cleared by reset", gate_out, 1'b0);
    host_wr("R3 disarmed by reset", 1'b1, 8'hD1, 1'b0, 1'b0);
    host_wr("R1 data after reset", 1'b0, 8'h02, 1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_unarmed();
    t_arm_same_cycle();
    t_set();
    t_clear();
    t_double();
    t_stray_ff();
    t_invalid();
    t_idle_data();
    t_stays_armed();
    t_reset_disarms();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule